// File: doc/BRIEF.md
# SPI-Addressed Output Control Register File

This block takes 16-bit command words from an SPI slave port and writes them into a small set of configuration registers. These registers control four high-side and eight low-side output channels. For each of the twelve channels it computes the final on/off drive. The drive joins a software-written output bit with a hardware input source. A per-channel mode bit chooses whether the two are ANDed or ORed. Each high-side channel has a private input pin. All eight low-side channels share one common input pin, and that pin takes part only while a gate enable is set.

The block also holds a current-sense routing register and an open-load detection register, and drives the matching control outputs. The SPI signals are brought into the system clock domain through synchronizers. Data is captured on rising SCLK edges, most significant bit first. A word is acted on only when chip select goes high after exactly 16 clocks.

Top module: `ocr_top`

## Requirements
- R1: A word is 16 bits, sent MSB first (bit 15 first). Bits 15..13 hold the address and bits 11..0 hold channel data, where bits 3..0 are high-side channels 0..3 and bits 11..4 are low-side channels 4..11. Bit 12 (watchdog) has no effect on any output.
- R2: A word is committed only when chip select rises after exactly 16 SCLK rising edges. With 15 or 17 edges the word is discarded and nothing changes.
- R3: After reset the output register, the low-side gate enable, the sense register and the open-load register are zero. The mode register is all ones (AND), so every drive output is low.
- R4: Address 0 writes the output register and address 1 writes the mode register. When a channel's mode bit is 1, its drive is the AND of its source and its output bit.
- R5: When a channel's mode bit is 0, its drive is the OR of its source and its output bit.
- R6: The source of high-side channel i is hs_in_i[i]. The source of every low-side channel is ls_in_i AND the gate enable, which is bit 0 written at address 2. While the enable is 0 the low-side source is 0.
- R7: Address 3 bits 3..0 set sense_sel_o. sense_pin_o[0] is high when channel 0 or 1 is selected, and sense_pin_o[1] is high when channel 2 or 3 is selected.
- R8: Address 4 writes the open-load register. For high-side channels ol_en_o is the inverse of the stored bit (1 disables detection). For low-side channels ol_en_o equals the stored bit (1 enables detection).
- R9: Writes to addresses 5, 6 (unused) and 7 (test) change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI clock |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI serial data in |
| hs_in_i | input | 4 | Per-channel hardware inputs for the high-side channels |
| ls_in_i | input | 1 | Shared hardware input for the low-side channels |
| drive_o | output | 12 | Final on/off drive per channel |
| sense_sel_o | output | 4 | Current-sense routing per high-side channel |
| sense_pin_o | output | 2 | Sense pin active (pair 0/1, pair 2/3) |
| ol_en_o | output | 12 | Off-state open-load detection enable per channel |

## Verification
The combining logic is exercised with the output register both all ones and all zeros. This is repeated under AND and OR mode, with the high-side pins set to all ones and then to alternating values. A wrong operator or a swapped channel shows up in these cases. The shared low-side pin is toggled with the gate enable both off and on, which shows the gating separately from the mode. Frames of 15 and 17 bits and writes to the three inert addresses are each followed by a full output compare, so a state change is detected. The sense and open-load patterns are chosen so that a pair-merging error or a polarity inversion between the high and low sides shows up on its own.

// File: rtl/ocr_pkg.sv
package ocr_pkg;
  localparam int unsigned FRAME_W = 16;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned NUM_HS  = 4;
  localparam int unsigned NUM_LS  = 8;
  localparam int unsigned NUM_CH  = NUM_HS + NUM_LS;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);

  typedef enum logic [ADDR_W-1:0] {
    A_OUT  = 3'd0,
    A_MODE = 3'd1,
    A_GATE = 3'd2,
    A_SNS  = 3'd3,
    A_OLD  = 3'd4,
    A_R5   = 3'd5,
    A_NONE = 3'd6,
    A_TEST = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/ocr_spi_rx.sv
module ocr_spi_rx
  import ocr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               cs_ni,
  input  logic               mosi_i,
  output logic               sclk_rise_o,
  output logic               cs_fall_o,
  output logic               wr_en_o,
  output logic [FRAME_W-1:0] wr_word_o
);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [2:0] sclk_sy, cs_sy;
  logic [1:0] mosi_sy;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic cs_rise, active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_sy <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
    end else begin
      sclk_sy <= {sclk_sy[1:0], sclk_i};
      cs_sy   <= {cs_sy[1:0], cs_ni};
      mosi_sy <= {mosi_sy[0], mosi_i};
    end
  end

  assign sclk_rise_o = sclk_sy[1] & ~sclk_sy[2];
  assign cs_fall_o   = ~cs_sy[1] & cs_sy[2];
  assign cs_rise     = cs_sy[1] & ~cs_sy[2];
  assign active      = ~cs_sy[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      wr_en_o   <= 1'b0;
      wr_word_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (cs_fall_o) begin
        cnt_q <= '0;
      end else if (sclk_rise_o && active) begin
        sh_q <= {sh_q[FRAME_W-2:0], mosi_sy[1]};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
      if (cs_rise && cnt_q == CNT_FULL) begin
        wr_en_o   <= 1'b1;
        wr_word_o <= sh_q;
      end
    end
  end
endmodule

// File: rtl/ocr_regs.sv
module ocr_regs
  import ocr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [FRAME_W-1:0] wr_word_i,
  output logic [NUM_CH-1:0]  out_q_o,
  output logic [NUM_CH-1:0]  mode_q_o,
  output logic               gate_q_o,
  output logic [NUM_HS-1:0]  sns_q_o,
  output logic [NUM_CH-1:0]  ol_q_o
);
  reg_addr_e             addr;
  logic [NUM_CH-1:0]     data;

  assign addr = reg_addr_e'(wr_word_i[FRAME_W-1 -: ADDR_W]);
  assign data = wr_word_i[NUM_CH-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q_o  <= '0;
      mode_q_o <= '1;
      gate_q_o <= 1'b0;
      sns_q_o  <= '0;
      ol_q_o   <= '0;
    end else if (wr_en_i) begin
      unique case (addr)
        A_OUT:  out_q_o  <= data;
        A_MODE: mode_q_o <= data;
        A_GATE: gate_q_o <= data[0];
        A_SNS:  sns_q_o  <= data[NUM_HS-1:0];
        A_OLD:  ol_q_o   <= data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ocr_chan_mix.sv
module ocr_chan_mix
  import ocr_pkg::*;
(
  input  logic [NUM_HS-1:0] hs_in_i,
  input  logic              ls_in_i,
  input  logic              gate_i,
  input  logic [NUM_CH-1:0] out_i,
  input  logic [NUM_CH-1:0] mode_i,
  input  logic [NUM_CH-1:0] ol_i,
  output logic [NUM_CH-1:0] drive_o,
  output logic [NUM_CH-1:0] ol_en_o
);
  logic ls_src;
  assign ls_src = ls_in_i & gate_i;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic src;
    if (i < NUM_HS) begin : g_hs
      assign src        = hs_in_i[i];
      assign ol_en_o[i] = ~ol_i[i];
    end else begin : g_ls
      assign src        = ls_src;
      assign ol_en_o[i] = ol_i[i];
    end
    assign drive_o[i] = mode_i[i] ? (src & out_i[i]) : (src | out_i[i]);
  end
endmodule

// File: rtl/ocr_top.sv
module ocr_top
  import ocr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic [3:0]        hs_in_i,
  input  logic              ls_in_i,
  output logic [11:0]       drive_o,
  output logic [3:0]        sense_sel_o,
  output logic [1:0]        sense_pin_o,
  output logic [11:0]       ol_en_o
);
  logic               sclk_rise, cs_fall, wr_en;
  logic [FRAME_W-1:0] wr_word;
  logic [NUM_CH-1:0]  out_q, mode_q, ol_q;
  logic               gate_q;
  logic [NUM_HS-1:0]  sns_q;

  ocr_spi_rx i_rx (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .sclk_rise_o(sclk_rise), .cs_fall_o(cs_fall),
    .wr_en_o(wr_en), .wr_word_o(wr_word)
  );

  ocr_regs i_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_word_i(wr_word),
    .out_q_o(out_q), .mode_q_o(mode_q), .gate_q_o(gate_q),
    .sns_q_o(sns_q), .ol_q_o(ol_q)
  );

  ocr_chan_mix i_mix (
    .hs_in_i, .ls_in_i, .gate_i(gate_q), .out_i(out_q), .mode_i(mode_q),
    .ol_i(ol_q), .drive_o, .ol_en_o
  );

  assign sense_sel_o = sns_q;
  for (genvar p = 0; p < NUM_HS/2; p++) begin : g_pair
    assign sense_pin_o[p] = |sns_q[2*p +: 2];
  end
endmodule

// File: rtl/ocr_checker.sv
module ocr_checker
  import ocr_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sclk_rise,
  input logic               cs_fall,
  input logic               cs_ni,
  input logic               wr_en,
  input logic [FRAME_W-1:0] wr_word,
  input logic [NUM_CH-1:0]  out_q,
  input logic [NUM_CH-1:0]  mode_q,
  input logic [NUM_CH-1:0]  drive_o,
  input logic [3:0]         sense_sel_o,
  input logic [NUM_CH-1:0]  ol_en_o
);
  logic [CNT_W-1:0] chk_cnt;
  logic             in_frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_cnt  <= '0;
      in_frame <= 1'b0;
    end else if (cs_fall) begin
      chk_cnt  <= '0;
      in_frame <= 1'b1;
    end else if (sclk_rise && chk_cnt != CNT_W'(FRAME_W + 1)) begin
      chk_cnt <= chk_cnt + 1'b1;
    end
  end

  assert_commit_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (in_frame && chk_cnt == CNT_W'(FRAME_W)));

  assert_and_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o & mode_q & ~out_q) == '0);

  assert_or_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~mode_q & out_q & ~drive_o) == '0);

  assert_sense_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_word[15:13] == 3'd3) |=> sense_sel_o == $past(wr_word[3:0]));

  assert_inert_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_word[15:13] >= 3'd5) |=>
      ($stable(out_q) && $stable(mode_q) && $stable(sense_sel_o) && $stable(ol_en_o)));
endmodule

bind ocr_top ocr_checker i_checker (
  .clk_i, .rst_ni, .sclk_rise, .cs_fall, .cs_ni, .wr_en, .wr_word,
  .out_q, .mode_q, .drive_o, .sense_sel_o, .ol_en_o
);

// File: tb/test_ocr_top.sv
module test_ocr_top;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, cs_n = 1, mosi = 0;
  logic [3:0] hs_in = 4'hF;
  logic ls_in = 1'b1;
  logic [11:0] drive, ol_en;
  logic [3:0] sns_sel;
  logic [1:0] sns_pin;

  always #10 clk = ~clk;

  ocr_top i_ocr_top (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .hs_in_i(hs_in), .ls_in_i(ls_in), .drive_o(drive),
    .sense_sel_o(sns_sel), .sense_pin_o(sns_pin), .ol_en_o(ol_en)
  );

  typedef struct {
    logic [11:0] drv;
    logic [3:0]  sel;
    logic [1:0]  pin;
    logic [11:0] ole;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model of the register contents
  logic [11:0] m_out = 0, m_mode = 12'hFFF, m_ol = 0;
  logic        m_gate = 0;
  logic [3:0]  m_sns = 0;

  function automatic exp_t model(string tag);
    exp_t e;
    logic src;
    for (int i = 0; i < 12; i++) begin
      src = (i < 4) ? hs_in[i] : (ls_in & m_gate);
      e.drv[i] = m_mode[i] ? (src & m_out[i]) : (src | m_out[i]);
      e.ole[i] = (i < 4) ? ~m_ol[i] : m_ol[i];
    end
    e.sel = m_sns;
    e.pin = {m_sns[3] | m_sns[2], m_sns[1] | m_sns[0]};
    e.tag = tag;
    return e;
  endfunction

  task automatic push(string tag);
    repeat (8) @(negedge clk);
    sb_q.push_back(model(tag));
  endtask

  task automatic frame(logic [16:0] bits, int n);
    @(negedge clk); cs_n = 0;
    repeat (4) @(negedge clk);
    for (int b = n - 1; b >= 0; b--) begin
      mosi = bits[b];
      repeat (4) @(negedge clk); sclk = 1;
      repeat (4) @(negedge clk); sclk = 0;
    end
    repeat (4) @(negedge clk); cs_n = 1;
  endtask

  task automatic wr(logic [2:0] a, logic [11:0] d, bit wd, string tag);
    frame({1'b0, a, wd, d}, 16);
    case (a)
      3'd0: m_out  = d;
      3'd1: m_mode = d;
      3'd2: m_gate = d[0];
      3'd3: m_sns  = d[3:0];
      3'd4: m_ol   = d;
      default: ;
    endcase
    push(tag);
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (drive !== e.drv || sns_sel !== e.sel || sns_pin !== e.pin || ol_en !== e.ole) begin
        n_fail++;
        $display("FAIL %s: drive=%h sel=%h pin=%h ol=%h expected drive=%h sel=%h pin=%h ol=%h",
                 e.tag, drive, sns_sel, sns_pin, ol_en, e.drv, e.sel, e.pin, e.ole);
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk); rst_n = 1;
    push("R3 reset state");
    wr(3'd0, 12'hFFF, 1'b1, "R1 R4 R6 out all ones, gate off, wd bit set");
    wr(3'd2, 12'h001, 1'b0, "R6 gate enabled");
    @(negedge clk); hs_in = 4'b0101; ls_in = 0; push("R4 alternating pins");
    wr(3'd1, 12'h000, 1'b0, "R5 OR mode all ones");
    wr(3'd0, 12'h000, 1'b0, "R5 OR mode out zero");
    @(negedge clk); ls_in = 1; push("R5 R6 shared pin high");
    wr(3'd2, 12'h000, 1'b0, "R6 gate disabled");
    frame({1'b0, 3'd0, 1'b0, 12'hAAA}, 15); push("R2 short frame ignored");
    frame({3'd0, 1'b0, 12'hAAA, 1'b1}, 17); push("R2 long frame ignored");
    wr(3'd3, 12'h004, 1'b0, "R7 sense ch2");
    wr(3'd3, 12'h003, 1'b0, "R7 sense ch0+ch1");
    wr(3'd4, 12'h00F, 1'b0, "R8 hs open-load disabled");
    wr(3'd4, 12'h0F0, 1'b0, "R8 ls open-load enabled");
    wr(3'd1, 12'h0F3, 1'b0, "R4 R5 mixed modes");
    wr(3'd5, 12'hFFF, 1'b0, "R9 addr 5 ignored");
    wr(3'd6, 12'hFFF, 1'b0, "R9 addr 6 ignored");
    wr(3'd7, 12'hFFF, 1'b1, "R9 test addr ignored");
    @(negedge clk); hs_in = 4'b1010; push("R4 R5 pins flipped");
    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule